// File: doc/BRIEF.md
# Collision Retry Backoff Timer

This block decides when a transmitter on a shared half-duplex medium may try again after its frame collides with another station's frame. A new transmit command empties a 16-bit window mask. Each collision shifts a one into the low end of that mask. The block then loads a wait interval, which is the mask ANDed with a free-running counter value supplied from outside. On every periodic tick the block decrements this interval. When a tick finds the interval already at zero, the block emits a one-cycle retry pulse.

Each new one in the mask doubles the range of possible waits, so the mean wait doubles with every consecutive collision. When a collision fills the top bit of the mask, the block stops retrying and raises a failure flag. The flag stays up until the next transmit command. A transmit-complete input ends the sequence early and cancels any countdown in progress.

Carrier sensing and the serial transmitter are outside this block. The transmitter reports collisions and completions to the block, and it restarts a frame whenever it sees the retry pulse.

Top module: `backoff_timer`

## Requirements
- R1: After reset, and in the cycle after a `start_i` pulse, `fail_o` and `waiting_o` are 0 and `coll_cnt_o` is 0. `start_i` also empties the window mask, so the next collision gives a window of exactly bit 0.
- R2: A collision while the block is transmitting (after a start or a retry) shifts a one into bit 0 of the window mask and increments `coll_cnt_o` by one.
- R3: The wait interval is the window mask ANDed with `rand_i` as sampled in the collision cycle. Bits of `rand_i` above the mask have no effect on the wait.
- R4: While `waiting_o` is high, each `tick_i` cycle decrements the interval. `retry_o` goes high for exactly one cycle, in the cycle after the tick that finds the interval at zero. An interval of N therefore retries on the (N+1)-th tick.
- R5: A collision that sets the top bit of the mask (the MASK_W-th consecutive collision) sets `fail_o`, starts no countdown and never yields `retry_o`.
- R6: An interval that computes to zero retries on the first tick after the collision.
- R7: `done_i` returns the block to idle and cancels a pending countdown. No later tick produces `retry_o`.
- R8: `fail_o` remains high through ticks, collisions and `done_i`, and clears only on `start_i`.
- R9: Collisions that arrive while idle, while counting down or while failed change neither `coll_cnt_o` nor the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | New transmit command pulse |
| collide_i | input | 1 | Collision detected pulse |
| done_i | input | 1 | Transmit completed pulse |
| tick_i | input | 1 | Periodic countdown tick |
| rand_i | input | MASK_W | Free-running counter value |
| retry_o | output | 1 | One-cycle retry-now pulse |
| fail_o | output | 1 | Gave up after mask overflow |
| waiting_o | output | 1 | Countdown in progress |
| coll_cnt_o | output | $clog2(MASK_W+1) | Collisions since the last start |

## Verification
The bench builds the block with the default MASK_W of 16. It drives `rand_i` directly, which lets it pick intervals exactly: zero, full-mask and partially masked values. Feeding a zero counter value makes every wait end on the first tick, so all sixteen collisions up to the give-up point fit into a short run. The 16-bit width also leaves high counter bits that must be masked away, and the bench checks that they are.

// File: rtl/backoff_timer.sv
module backoff_timer #(
  parameter int MASK_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic                         collide_i,
  input  logic                         done_i,
  input  logic                         tick_i,
  input  logic [MASK_W-1:0]            rand_i,
  output logic                         retry_o,
  output logic                         fail_o,
  output logic                         waiting_o,
  output logic [$clog2(MASK_W+1)-1:0]  coll_cnt_o
);
  localparam int CW = $clog2(MASK_W+1);
  localparam logic [CW-1:0]     CNT_ONE = CW'(1);
  localparam logic [MASK_W-1:0] IV_ONE  = MASK_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_TX, S_WAIT, S_FAIL} st_t;

  st_t               st_q;
  logic [MASK_W-1:0] mask_q;
  logic [MASK_W-1:0] ival_q;
  logic [CW-1:0]     cnt_q;

  wire [MASK_W-1:0] mask_nx = {mask_q[MASK_W-2:0], 1'b1};
  wire              full_nx = mask_nx[MASK_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      mask_q  <= '0;
      ival_q  <= '0;
      cnt_q   <= '0;
      retry_o <= 1'b0;
    end else begin
      retry_o <= 1'b0;
      if (start_i) begin
        st_q   <= S_TX;
        mask_q <= '0;
        ival_q <= '0;
        cnt_q  <= '0;
      end else if (done_i) begin
        if (st_q != S_FAIL) st_q <= S_IDLE;
        ival_q <= '0;
      end else begin
        unique case (st_q)
          S_TX: if (collide_i) begin
            mask_q <= mask_nx;
            cnt_q  <= cnt_q + CNT_ONE;
            if (full_nx) begin
              st_q <= S_FAIL;
            end else begin
              ival_q <= mask_nx & rand_i;
              st_q   <= S_WAIT;
            end
          end
          S_WAIT: if (tick_i) begin
            if (ival_q == '0) begin
              retry_o <= 1'b1;
              st_q    <= S_TX;
            end else begin
              ival_q <= ival_q - IV_ONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign fail_o     = (st_q == S_FAIL);
  assign waiting_o  = (st_q == S_WAIT);
  assign coll_cnt_o = cnt_q;

  // R1
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!fail_o && !waiting_o && coll_cnt_o == '0));

  // R4
  retry_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_o |=> !retry_o);

  // R4
  retry_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_o |-> ($past(tick_i) && $past(waiting_o)));

  // R5
  fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> (!retry_o && !waiting_o));

  // R8
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !start_i) |=> fail_o);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !start_i) |=> (!waiting_o && !retry_o));

  // R9
  wait_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting_o && collide_i && !start_i && !done_i) |=> $stable(coll_cnt_o));
endmodule

// File: tb/sim_backoff_timer.sv
`timescale 1ns/1ps
module sim_backoff_timer;
  localparam int MW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, collide_i = 0, done_i = 0, tick_i = 0;
  logic [MW-1:0] rand_i = '0;
  logic retry_o, fail_o, waiting_o;
  logic [4:0] coll_cnt_o;
  int total = 0, bad = 0, cyc = 0;
  int exp_q[$];
  bit finished = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  backoff_timer #(.MASK_W(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .collide_i(collide_i),
    .done_i(done_i), .tick_i(tick_i), .rand_i(rand_i), .retry_o(retry_o),
    .fail_o(fail_o), .waiting_o(waiting_o), .coll_cnt_o(coll_cnt_o));

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: every retry pulse must match the next expected cycle (R4)
  always @(negedge clk) if (rst_n && retry_o) begin
    if (exp_q.size() == 0) check("R4/R7 unexpected retry", cyc, -1);
    else check("R4 retry cycle", cyc, exp_q.pop_front());
  end

  task automatic pulse_start;
    @(negedge clk) start_i = 1; @(negedge clk) start_i = 0;
  endtask
  task automatic pulse_done;
    @(negedge clk) done_i = 1; @(negedge clk) done_i = 0;
  endtask
  task automatic collide(input logic [MW-1:0] rv);
    @(negedge clk) begin collide_i = 1; rand_i = rv; end
    @(negedge clk) collide_i = 0;
  endtask
  task automatic tick_exp(input bit want_retry);
    @(negedge clk) begin tick_i = 1; if (want_retry) exp_q.push_back(cyc + 1); end
    @(negedge clk) tick_i = 0;
  endtask
  task automatic ticks_then_retry(input int n);
    for (int k = 0; k < n; k++) tick_exp(0);
    tick_exp(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset fail", fail_o, 0);
    check("R1 reset waiting", waiting_o, 0);
    check("R1 reset count", coll_cnt_o, 0);
    // R9 idle: collision and ticks ignored
    collide(16'hFFFF);
    check("R9 idle collision count", coll_cnt_o, 0);
    tick_exp(0);
    tick_exp(0);

    pulse_start;
    collide(16'hFFFF);
    check("R2 count after 1", coll_cnt_o, 1);
    check("R4 waiting", waiting_o, 1);
    ticks_then_retry(1);                 // R3 mask 1 -> wait 1
    collide(16'hFFFF);
    check("R2 count after 2", coll_cnt_o, 2);
    ticks_then_retry(3);                 // R3 mask 3 -> wait 3
    collide(16'h0005);
    ticks_then_retry(5);                 // R3 mask 7 & 5
    collide(16'hFFF0);
    check("R2 count after 4", coll_cnt_o, 4);
    ticks_then_retry(0);                 // R6 zero wait, R3 high bits masked
    collide(16'h0010);                   // mask 1F -> wait 16
    tick_exp(0);
    collide(16'hFFFF);                   // R9 ignored while waiting
    check("R9 waiting collision count", coll_cnt_o, 5);
    check("R9 still waiting", waiting_o, 1);
    pulse_done;
    check("R7 done cancels wait", waiting_o, 0);
    for (int k = 0; k < 20; k++) tick_exp(0);   // R7 no retry

    pulse_start;
    check("R1 start clears count", coll_cnt_o, 0);
    collide(16'hFFFF);
    ticks_then_retry(1);                 // R1 mask emptied -> wait 1

    // R5 overflow
    pulse_start;
    for (int i = 1; i < MW; i++) begin
      collide('0);
      ticks_then_retry(0);
    end
    check("R5 count before overflow", coll_cnt_o, MW - 1);
    check("R5 no fail yet", fail_o, 0);
    collide('0);
    check("R5 fail set", fail_o, 1);
    check("R5 no wait", waiting_o, 0);
    check("R5 count", coll_cnt_o, MW);
    tick_exp(0);
    tick_exp(0);
    collide(16'hFFFF);
    check("R9 failed collision count", coll_cnt_o, MW);
    pulse_done;
    check("R8 fail held after done", fail_o, 1);
    pulse_start;
    check("R8 start clears fail", fail_o, 0);
    check("R1 start clears count again", coll_cnt_o, 0);

    repeat (3) @(negedge clk);
    check("R4 all expected retries seen", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      check("watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule